// File: doc/BRIEF.md
# Acknowledgment Counter Bank with Network Mailbox and Reply Slot

This block tracks the progress of remote DMA transfers. It holds 128 counters. Software loads each counter with the number of acknowledgment units it expects, and chooses per counter what happens on completion. The network then delivers acknowledgments, and each one carries an amount. When a counter's remaining count is used up, the block can pulse an interrupt, emit a notification aimed at a counter on some node, or do both. Software may poll any counter at any time through a combinational read port.

Beside the counters sit two network-written stores. The first is a 4 KB mailbox, held as a circular queue of 32-bit words. The network appends to it and the CPU pops from it. When the queue is full, an arriving word is discarded and a sticky overflow flag is raised. A pop from an empty queue returns a response marked empty. The second is a one-word reply slot that receives the answers to remote register reads. A full flag marks it as holding data, and a CPU read clears that flag. The packet format and the transport are outside this block.

Top module: `ackctr_mbox_unit`

## Requirements
- R1: After synchronous reset, every counter reads 0, the mailbox is empty, the overflow flag and the slot full flag are 0, and neither the interrupt pulse nor the notification pulse is asserted.
- R2: A CPU counter write loads the 16-bit remaining count, the interrupt enable, the notify enable, the 7-bit target counter index and the 8-bit target node of the addressed counter. The poll port returns the new count combinationally from the next cycle.
- R3: An acknowledgment whose amount is smaller than the counter's nonzero remaining count lowers that count by the amount and produces no event. An amount of 0 leaves the count unchanged.
- R4: An acknowledgment whose amount is equal to or larger than a nonzero remaining count sets the count to 0. In the next cycle it asserts irq_valid with the counter index for exactly one cycle if the interrupt enable is set, and ntf_valid with the stored target index and node for exactly one cycle if the notify enable is set.
- R5: An acknowledgment to a counter whose count is 0 changes nothing and produces no event, so completion fires only once per load.
- R6: When a CPU write and an acknowledgment address the same counter in the same cycle, the CPU write takes effect and the acknowledgment is discarded with no event.
- R7: The mailbox returns words in arrival order and holds 1024 words of 32 bits. A pop response appears one cycle after the pop request.
- R8: A mailbox write that arrives while 1024 words are held is discarded and sets mb_overflow. mb_overflow then stays 1 until reset.
- R9: A pop while the mailbox is empty yields a response with cpu_mb_rempty at 1 and cpu_mb_rdata at 0. A write that arrives in the same cycle is kept for a later pop.
- R10: A slot write stores its word and sets slot_full in the next cycle, replacing any earlier word. A CPU slot read clears slot_full in the next cycle, unless a slot write arrives in the same cycle, in which case slot_full stays 1 and holds the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_cw_valid | input | 1 | CPU counter write strobe |
| cpu_cw_idx | input | 7 | Counter to write |
| cpu_cw_count | input | 16 | Remaining acknowledgment count to load |
| cpu_cw_irq_en | input | 1 | Interrupt on completion |
| cpu_cw_ntf_en | input | 1 | Notification on completion |
| cpu_cw_tgt_idx | input | 7 | Counter index that the notification targets |
| cpu_cw_tgt_node | input | 8 | Node that the notification targets |
| cpu_poll_idx | input | 7 | Counter to poll |
| cpu_poll_count | output | 16 | Current count of the polled counter |
| net_ack_valid | input | 1 | Acknowledgment arrives |
| net_ack_idx | input | 7 | Counter the acknowledgment targets |
| net_ack_amt | input | 16 | Amount carried by the acknowledgment |
| irq_valid | output | 1 | One-cycle completion interrupt |
| irq_idx | output | 7 | Counter that completed |
| ntf_valid | output | 1 | One-cycle notification request |
| ntf_tgt_idx | output | 7 | Target counter of the notification |
| ntf_tgt_node | output | 8 | Target node of the notification |
| net_mb_valid | input | 1 | Mailbox word arrives |
| net_mb_data | input | 32 | Mailbox word |
| cpu_mb_rd | input | 1 | CPU pop request |
| cpu_mb_rvalid | output | 1 | Pop response valid |
| cpu_mb_rempty | output | 1 | Pop found the mailbox empty |
| cpu_mb_rdata | output | 32 | Popped word, 0 when empty |
| mb_overflow | output | 1 | Sticky flag for a dropped mailbox word |
| net_slot_valid | input | 1 | Remote read reply arrives |
| net_slot_data | input | 32 | Reply word |
| cpu_slot_rd | input | 1 | CPU reads the slot and clears full |
| slot_full | output | 1 | Slot holds an unread reply |
| slot_data | output | 32 | Slot contents |

## Verification
Every one of the 128 counters is loaded with a distinct count and a distinct combination of enables and target. It then receives a partial acknowledgment, an overshooting acknowledgment and a late acknowledgment. This separates plain decrement, completion with each enable pattern, and the fire-once rule, and it also shows index decoding errors. The mailbox is filled to exactly its capacity with arithmetic data and pushed once more. It is then drained to one read past empty. This separates ordering, the capacity boundary, the drop-and-flag behaviour and the empty response. Same-cycle collisions are driven explicitly: a CPU write against an acknowledgment, a write against a pop on an empty queue, and a slot write against a slot read. Each of these shows whether the priority rule holds.

// File: rtl/ackctr_pkg.sv
package ackctr_pkg;

    localparam int NUM_CTR = 128;
    localparam int IDX_W   = $clog2(NUM_CTR);
    localparam int CNT_W   = 16;
    localparam int NODE_W  = 8;

    typedef logic [IDX_W-1:0] ctr_idx_t;
    typedef logic [CNT_W-1:0] ctr_cnt_t;

    typedef struct packed {
        logic                  irq_en;
        logic                  ntf_en;
        logic [IDX_W-1:0]      tgt_idx;
        logic [NODE_W-1:0]     tgt_node;
    } ctr_cfg_t;

    typedef struct packed {
        logic     fire;
        ctr_cnt_t next;
    } ack_res_t;

    // Result of applying one acknowledgment amount to a remaining count.
    function automatic ack_res_t ack_step(input ctr_cnt_t cur, input ctr_cnt_t amt);
        ack_res_t r;
        r.fire = (cur != '0) && (amt >= cur);
        if (r.fire || cur == '0)
            r.next = '0;
        else
            r.next = cur - amt;
        return r;
    endfunction

endpackage

// File: rtl/ackctr_bank.sv
module ackctr_bank
    import ackctr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_valid,
    input  ctr_idx_t wr_idx,
    input  ctr_cnt_t wr_cnt,
    input  ctr_cfg_t wr_cfg,
    input  logic     ack_valid,
    input  ctr_idx_t ack_idx,
    input  ctr_cnt_t ack_amt,
    input  ctr_idx_t poll_idx,
    output ctr_cnt_t poll_cnt,
    output logic     evt_irq,
    output ctr_idx_t evt_irq_idx,
    output logic     evt_ntf,
    output ctr_idx_t evt_ntf_idx,
    output logic [NODE_W-1:0] evt_ntf_node
);
    ctr_cnt_t cnt [NUM_CTR];
    ctr_cfg_t cfg [NUM_CTR];

    logic     ack_take;
    ack_res_t res;

    always_comb begin
        ack_take = ack_valid && !(wr_valid && wr_idx == ack_idx);
        res      = ack_step(cnt[ack_idx], ack_amt);
        poll_cnt = cnt[poll_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CTR; i++) begin
                cnt[i] <= '0;
                cfg[i] <= '0;
            end
            evt_irq      <= 1'b0;
            evt_irq_idx  <= '0;
            evt_ntf      <= 1'b0;
            evt_ntf_idx  <= '0;
            evt_ntf_node <= '0;
        end else begin
            evt_irq <= 1'b0;
            evt_ntf <= 1'b0;
            if (ack_take) begin
                cnt[ack_idx] <= res.next;
                if (res.fire) begin
                    evt_irq      <= cfg[ack_idx].irq_en;
                    evt_irq_idx  <= ack_idx;
                    evt_ntf      <= cfg[ack_idx].ntf_en;
                    evt_ntf_idx  <= cfg[ack_idx].tgt_idx;
                    evt_ntf_node <= cfg[ack_idx].tgt_node;
                end
            end
            if (wr_valid) begin
                cnt[wr_idx] <= wr_cnt;
                cfg[wr_idx] <= wr_cfg;
            end
        end
    end
endmodule

// File: rtl/ackctr_mbox_queue.sv
module ackctr_mbox_queue #(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop_req,
    output logic              rvalid,
    output logic              rempty,
    output logic [WORD_W-1:0] rdata,
    output logic              overflow,
    output logic              full
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     head, tail;
    logic [AW:0]       level;
    logic              empty, do_push, do_pop;

    always_comb begin
        full    = (level == (AW+1)'(DEPTH));
        empty   = (level == '0);
        do_push = push && !full;
        do_pop  = pop_req && !empty;
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[tail] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head     <= '0;
            tail     <= '0;
            level    <= '0;
            rvalid   <= 1'b0;
            rempty   <= 1'b0;
            rdata    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) tail <= tail + 1'b1;
            if (do_pop)  head <= head + 1'b1;
            level  <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
            rvalid <= pop_req;
            rempty <= pop_req && empty;
            rdata  <= do_pop ? mem[head] : '0;
            if (push && full)
                overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/ackctr_slot.sv
module ackctr_slot #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd,
    output logic              full,
    output logic [WORD_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (rd) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/ackctr_mbox_unit.sv
module ackctr_mbox_unit
    import ackctr_pkg::*;
#(
    parameter int MBOX_BYTES = 4096,
    parameter int WORD_W     = 32,
    localparam int MBOX_DEPTH = MBOX_BYTES / (WORD_W / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_cw_valid,
    input  logic [IDX_W-1:0]  cpu_cw_idx,
    input  logic [CNT_W-1:0]  cpu_cw_count,
    input  logic              cpu_cw_irq_en,
    input  logic              cpu_cw_ntf_en,
    input  logic [IDX_W-1:0]  cpu_cw_tgt_idx,
    input  logic [NODE_W-1:0] cpu_cw_tgt_node,
    input  logic [IDX_W-1:0]  cpu_poll_idx,
    output logic [CNT_W-1:0]  cpu_poll_count,
    input  logic              net_ack_valid,
    input  logic [IDX_W-1:0]  net_ack_idx,
    input  logic [CNT_W-1:0]  net_ack_amt,
    output logic              irq_valid,
    output logic [IDX_W-1:0]  irq_idx,
    output logic              ntf_valid,
    output logic [IDX_W-1:0]  ntf_tgt_idx,
    output logic [NODE_W-1:0] ntf_tgt_node,
    input  logic              net_mb_valid,
    input  logic [WORD_W-1:0] net_mb_data,
    input  logic              cpu_mb_rd,
    output logic              cpu_mb_rvalid,
    output logic              cpu_mb_rempty,
    output logic [WORD_W-1:0] cpu_mb_rdata,
    output logic              mb_overflow,
    input  logic              net_slot_valid,
    input  logic [WORD_W-1:0] net_slot_data,
    input  logic              cpu_slot_rd,
    output logic              slot_full,
    output logic [WORD_W-1:0] slot_data
);
    ctr_cfg_t wr_cfg;
    logic     mb_full;

    always_comb begin
        wr_cfg.irq_en   = cpu_cw_irq_en;
        wr_cfg.ntf_en   = cpu_cw_ntf_en;
        wr_cfg.tgt_idx  = cpu_cw_tgt_idx;
        wr_cfg.tgt_node = cpu_cw_tgt_node;
    end

    ackctr_bank u_bank (
        .clk(clk), .rst(rst),
        .wr_valid(cpu_cw_valid), .wr_idx(cpu_cw_idx), .wr_cnt(cpu_cw_count), .wr_cfg(wr_cfg),
        .ack_valid(net_ack_valid), .ack_idx(net_ack_idx), .ack_amt(net_ack_amt),
        .poll_idx(cpu_poll_idx), .poll_cnt(cpu_poll_count),
        .evt_irq(irq_valid), .evt_irq_idx(irq_idx),
        .evt_ntf(ntf_valid), .evt_ntf_idx(ntf_tgt_idx), .evt_ntf_node(ntf_tgt_node)
    );

    ackctr_mbox_queue #(.DEPTH(MBOX_DEPTH), .WORD_W(WORD_W)) u_mbox (
        .clk(clk), .rst(rst),
        .push(net_mb_valid), .push_data(net_mb_data), .pop_req(cpu_mb_rd),
        .rvalid(cpu_mb_rvalid), .rempty(cpu_mb_rempty), .rdata(cpu_mb_rdata),
        .overflow(mb_overflow), .full(mb_full)
    );

    ackctr_slot #(.WORD_W(WORD_W)) u_slot (
        .clk(clk), .rst(rst),
        .wr(net_slot_valid), .wr_data(net_slot_data), .rd(cpu_slot_rd),
        .full(slot_full), .data(slot_data)
    );
endmodule

// File: rtl/ackctr_checker.sv
module ackctr_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              net_ack_valid,
    input logic              irq_valid,
    input logic              ntf_valid,
    input logic              net_mb_valid,
    input logic              mb_full,
    input logic              mb_overflow,
    input logic              cpu_mb_rd,
    input logic              cpu_mb_rvalid,
    input logic              cpu_mb_rempty,
    input logic [WORD_W-1:0] cpu_mb_rdata,
    input logic              net_slot_valid,
    input logic              cpu_slot_rd,
    input logic              slot_full
);
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> $past(net_ack_valid));
    p_ntf_cause_r4: assert property (@(posedge clk) disable iff (rst)
        ntf_valid |-> $past(net_ack_valid));
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        mb_overflow |=> mb_overflow);
    p_ovf_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(mb_overflow) |-> $past(mb_full && net_mb_valid));
    p_resp_src_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_mb_rvalid |-> $past(cpu_mb_rd));
    p_empty_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_mb_rvalid && cpu_mb_rempty) |-> (cpu_mb_rdata == '0));
    p_slot_set_r10: assert property (@(posedge clk) disable iff (rst)
        net_slot_valid |=> slot_full);
    p_slot_clr_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_slot_rd && !net_slot_valid) |=> !slot_full);
endmodule

bind ackctr_mbox_unit ackctr_checker #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst),
    .net_ack_valid(net_ack_valid), .irq_valid(irq_valid), .ntf_valid(ntf_valid),
    .net_mb_valid(net_mb_valid), .mb_full(mb_full), .mb_overflow(mb_overflow),
    .cpu_mb_rd(cpu_mb_rd), .cpu_mb_rvalid(cpu_mb_rvalid), .cpu_mb_rempty(cpu_mb_rempty),
    .cpu_mb_rdata(cpu_mb_rdata),
    .net_slot_valid(net_slot_valid), .cpu_slot_rd(cpu_slot_rd), .slot_full(slot_full)
);

// File: tb/sim_ackctr_mbox_unit.sv
module sim_ackctr_mbox_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_cw_valid = 0;
    logic [6:0]  cpu_cw_idx = 0;
    logic [15:0] cpu_cw_count = 0;
    logic        cpu_cw_irq_en = 0, cpu_cw_ntf_en = 0;
    logic [6:0]  cpu_cw_tgt_idx = 0;
    logic [7:0]  cpu_cw_tgt_node = 0;
    logic [6:0]  cpu_poll_idx = 0;
    logic [15:0] cpu_poll_count;
    logic        net_ack_valid = 0;
    logic [6:0]  net_ack_idx = 0;
    logic [15:0] net_ack_amt = 0;
    logic        irq_valid, ntf_valid;
    logic [6:0]  irq_idx, ntf_tgt_idx;
    logic [7:0]  ntf_tgt_node;
    logic        net_mb_valid = 0;
    logic [31:0] net_mb_data = 0;
    logic        cpu_mb_rd = 0;
    logic        cpu_mb_rvalid, cpu_mb_rempty, mb_overflow;
    logic [31:0] cpu_mb_rdata;
    logic        net_slot_valid = 0;
    logic [31:0] net_slot_data = 0;
    logic        cpu_slot_rd = 0;
    logic        slot_full;
    logic [31:0] slot_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ackctr_mbox_unit u0 (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic cwrite(input int idx, input int cnt, input bit ie, input bit ne,
                          input int tidx, input int tnode);
        cpu_cw_valid = 1; cpu_cw_idx = 7'(idx); cpu_cw_count = 16'(cnt);
        cpu_cw_irq_en = ie; cpu_cw_ntf_en = ne;
        cpu_cw_tgt_idx = 7'(tidx); cpu_cw_tgt_node = 8'(tnode);
        tick();
        cpu_cw_valid = 0;
    endtask

    task automatic ack(input int idx, input int amt);
        net_ack_valid = 1; net_ack_idx = 7'(idx); net_ack_amt = 16'(amt);
        tick();
        net_ack_valid = 0;
    endtask

    initial begin
        repeat (800000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired got=%h exp=%h", 32'd0, 32'd1);
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();

        // R1: reset state
        for (int i = 0; i < 128; i += 37) begin
            cpu_poll_idx = 7'(i); #1;
            chk(cpu_poll_count == 0, "R1 count after reset", 32'(cpu_poll_count), 0);
        end
        chk(!irq_valid && !ntf_valid, "R1 no events", {30'd0, irq_valid, ntf_valid}, 0);
        chk(!slot_full && !mb_overflow, "R1 flags", {30'd0, slot_full, mb_overflow}, 0);

        // R2: load all counters with distinct values and configuration
        for (int i = 0; i < 128; i++)
            cwrite(i, i + 1, i[0], i[1], 127 - i, (i * 3) % 256);
        for (int i = 0; i < 128; i++) begin
            cpu_poll_idx = 7'(i); #1;
            chk(cpu_poll_count == 16'(i + 1), "R2 readback", 32'(cpu_poll_count), 32'(i + 1));
        end

        // R3 R4 R5 sweep over every counter
        for (int i = 0; i < 128; i++) begin
            cpu_poll_idx = 7'(i);
            ack(i, i);  // leaves 1 (amount 0 when i is 0)
            chk(cpu_poll_count == 16'd1, "R3 partial decrement", 32'(cpu_poll_count), 1);
            chk(!irq_valid && !ntf_valid, "R3 no event", {30'd0, irq_valid, ntf_valid}, 0);
            ack(i, 3);  // overshoot completes
            chk(cpu_poll_count == 0, "R4 count zero", 32'(cpu_poll_count), 0);
            chk(irq_valid == i[0], "R4 irq enable", 32'(irq_valid), 32'(i[0]));
            if (i[0])
                chk(irq_idx == 7'(i), "R4 irq index", 32'(irq_idx), 32'(i));
            chk(ntf_valid == i[1], "R4 notify enable", 32'(ntf_valid), 32'(i[1]));
            if (i[1]) begin
                chk(ntf_tgt_idx == 7'(127 - i), "R4 notify index", 32'(ntf_tgt_idx), 32'(127 - i));
                chk(ntf_tgt_node == 8'((i * 3) % 256), "R4 notify node", 32'(ntf_tgt_node), 32'((i * 3) % 256));
            end
            ack(i, 5);  // late ack on zero count
            chk(!irq_valid && !ntf_valid, "R5 fires once / R4 one-cycle pulse",
                {30'd0, irq_valid, ntf_valid}, 0);
            chk(cpu_poll_count == 0, "R5 count stays zero", 32'(cpu_poll_count), 0);
        end

        // R4 exact-amount completion
        cwrite(9, 40, 1, 1, 2, 77);
        ack(9, 40);
        cpu_poll_idx = 7'd9; #1;
        chk(irq_valid && ntf_valid && cpu_poll_count == 0, "R4 exact amount",
            {15'd0, irq_valid, cpu_poll_count}, 32'h10000);

        // R6 collision: write wins, ack dropped
        cpu_cw_valid = 1; cpu_cw_idx = 7'd5; cpu_cw_count = 16'd10;
        cpu_cw_irq_en = 1; cpu_cw_ntf_en = 1; cpu_cw_tgt_idx = 0; cpu_cw_tgt_node = 0;
        net_ack_valid = 1; net_ack_idx = 7'd5; net_ack_amt = 16'd20;
        cpu_poll_idx = 7'd5;
        tick();
        cpu_cw_valid = 0; net_ack_valid = 0;
        chk(cpu_poll_count == 16'd10, "R6 write priority", 32'(cpu_poll_count), 10);
        chk(!irq_valid && !ntf_valid, "R6 ack dropped", {30'd0, irq_valid, ntf_valid}, 0);

        // R7 R8: fill mailbox to capacity, then one more
        net_mb_valid = 1;
        for (int k = 0; k < 1024; k++) begin
            net_mb_data = 32'(k) * 32'h9E3779B1 + 32'd7;
            tick();
        end
        net_mb_valid = 0;
        chk(!mb_overflow, "R8 no overflow at capacity", 32'(mb_overflow), 0);
        net_mb_valid = 1; net_mb_data = 32'hDEAD_BEEF;
        tick();
        net_mb_valid = 0;
        tick();
        chk(mb_overflow, "R8 overflow set", 32'(mb_overflow), 1);

        cpu_mb_rd = 1;
        for (int k = 0; k < 1024; k++) begin
            tick();
            chk(cpu_mb_rvalid && !cpu_mb_rempty && cpu_mb_rdata == 32'(k) * 32'h9E3779B1 + 32'd7,
                "R7 order", cpu_mb_rdata, 32'(k) * 32'h9E3779B1 + 32'd7);
        end
        tick();  // one past empty
        cpu_mb_rd = 0;
        chk(cpu_mb_rvalid && cpu_mb_rempty && cpu_mb_rdata == 0, "R9 empty response / R8 dropped word",
            cpu_mb_rdata, 0);
        chk(mb_overflow, "R8 overflow sticky", 32'(mb_overflow), 1);

        // R9 pop on empty with a simultaneous write
        cpu_mb_rd = 1; net_mb_valid = 1; net_mb_data = 32'h1234_5678;
        tick();
        net_mb_valid = 0;
        chk(cpu_mb_rempty, "R9 same-cycle write not seen", 32'(cpu_mb_rempty), 1);
        tick();
        cpu_mb_rd = 0;
        chk(!cpu_mb_rempty && cpu_mb_rdata == 32'h1234_5678, "R9 word kept", cpu_mb_rdata, 32'h1234_5678);

        // R10 slot
        net_slot_valid = 1; net_slot_data = 32'hA5A5_0001;
        tick();
        net_slot_valid = 0;
        chk(slot_full && slot_data == 32'hA5A5_0001, "R10 slot set", slot_data, 32'hA5A5_0001);
        net_slot_valid = 1; net_slot_data = 32'hA5A5_0002;
        tick();
        net_slot_valid = 0;
        chk(slot_full && slot_data == 32'hA5A5_0002, "R10 overwrite", slot_data, 32'hA5A5_0002);
        cpu_slot_rd = 1;
        tick();
        cpu_slot_rd = 0;
        chk(!slot_full, "R10 read clears", 32'(slot_full), 0);
        cpu_slot_rd = 1; net_slot_valid = 1; net_slot_data = 32'hA5A5_0003;
        tick();
        cpu_slot_rd = 0; net_slot_valid = 0;
        chk(slot_full && slot_data == 32'hA5A5_0003, "R10 write beats read", slot_data, 32'hA5A5_0003);

        done = 1;
        summary();
    end
endmodule